// File: doc/BRIEF.md
# Critical-Word-First Line Fill Buffer

This block handles an instruction-cache line miss. When the fetch unit misses, it opens a four-beat burst read that begins with the word the fetch unit asked for. The rest of the line follows in wrap-around order. Each beat is captured into a single-line buffer. The waiting fetch is answered in the same cycle that its word appears on the bus. Later fetches to the line under fill are answered either straight from the bus beat or from the buffer once the word has landed. A fetch for a word that has not yet arrived is held until that word comes in.

When a cacheable line is complete, the block asks to write the whole line into the cache array. That request steps aside in every cycle that a fetch lookup is present. For code marked caching-inhibited, the whole line is still fetched into the buffer but is never written to the array. Each buffered word may then be handed out only once, and asking for a word again starts a fresh burst.

The tag array, the choice of victim way and the external bus timing belong to neighbouring blocks. The caller signals a miss with `fetch_miss` and supplies the region attribute with `fetch_nc`.

Top module: `cwf_fill_buffer`

## Requirements
- R1: A fetch with `fetch_miss`=1 that matches no line held in the buffer, arriving while the buffer is free, raises `bus_req` for exactly one cycle, one clock later. In that cycle `bus_addr` equals the fetch address with its two byte bits cleared.
- R2: The burst returns four beats. Beat i (0..3) is stored as word (c+i) mod 4, where c is the requested word. The word within a line is selected by address bits [3:2], and the line is identified by bits [31:4].
- R3: The requested word is acknowledged in the same cycle that its beat is on the bus, and `fetch_data` carries that beat's `bus_data`.
- R4: A fetch to the line under fill behaves as follows. A word already captured is acknowledged at once from the buffer. A word arriving in that cycle is acknowledged with the bus data. A word not yet arrived gets no acknowledge until its beat lands.
- R5: A completed cacheable line holds `arr_wr_req` until `arr_wr_grant`. Word k of the line sits at `arr_line` bits [32k+31:32k], and `arr_line_addr` carries address bits [31:4]. One cycle after the grant, the request is low and the buffer is free.
- R6: `arr_wr_req` is low in every cycle in which a fetch is present, unless that fetch is a miss to a different line that is waiting for the buffer.
- R7: A miss to a different line raises no `bus_req` and gets no acknowledge while a fill is running or an array write is pending. It starts its burst in the cycle after the grant.
- R8: A caching-inhibited line is fetched in full into the buffer, and `arr_wr_req` is never raised for it.
- R9: In caching-inhibited mode, each buffered word is acknowledged at most once. Once the fill is complete, a repeat request for a used word starts a new burst for that word. A miss to another line discards the buffer immediately.
- R10: A fetch with `fetch_miss`=0 to a line not in the buffer gets no acknowledge and raises no `bus_req`.
- R11: After reset, `bus_req`, `fetch_ack` and `arr_wr_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch lookup present; held until acknowledged |
| fetch_addr | input | 32 | Byte address of the instruction fetch |
| fetch_miss | input | 1 | Tag lookup missed in the cache array |
| fetch_nc | input | 1 | Fetch lies in a caching-inhibited region |
| fetch_ack | output | 1 | Fetch served this cycle |
| fetch_data | output | 32 | Instruction word for the served fetch |
| bus_req | output | 1 | One-cycle burst read request |
| bus_addr | output | 32 | Address of the requested (first) word |
| bus_dv | input | 1 | Burst beat valid |
| bus_data | input | 32 | Burst beat data |
| bus_last | input | 1 | Marks the fourth beat |
| arr_wr_req | output | 1 | Request to write the buffered line into the array |
| arr_wr_grant | input | 1 | Array accepts the line this cycle |
| arr_line | output | 128 | Buffered line, word 0 in the low bits |
| arr_line_addr | output | 28 | Line address (address bits [31:4]) |

## Verification
The assertions are checked on every cycle. They cover the single-cycle burst request and the absence of a second request during a running fill. They also cover the array write never coinciding with a served fetch, the missing write request for caching-inhibited lines, and arrival bits that always track the beat count. The scenarios are needed for the rest. They show the wrap-around word placement and the same-cycle delivery of the critical word. They exercise stalls on words not yet arrived, the write stepping aside for array hits while proceeding for blocked misses, and the use-once refetch of a caching-inhibited word.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2,
    ST_HOLD  = 2'd3
  } fill_st_e;
endpackage

// File: rtl/cwf_beat_seq.sv
module cwf_beat_seq #(
  parameter int WORDS = 4,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OFF_W-1:0] start_word,
  input  logic             beat,
  output logic [OFF_W-1:0] word_idx,
  output logic [OFF_W:0]   beat_cnt
);
  logic [OFF_W-1:0] first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q  <= '0;
      beat_cnt <= '0;
    end else if (start) begin
      first_q  <= start_word;
      beat_cnt <= '0;
    end else if (beat) begin
      beat_cnt <= beat_cnt + 1'b1;
    end
  end

  // wrap-around order: requested word first, modulo the line size
  assign word_idx = first_q + beat_cnt[OFF_W-1:0];

  a_r2_beat_bound: assert property (@(posedge clk) disable iff (rst)
    32'(beat_cnt) <= WORDS);
endmodule

// File: rtl/cwf_line_store.sv
module cwf_line_store #(
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(WORDS),
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              use_en,
  input  logic [OFF_W-1:0]  use_idx,
  input  logic [OFF_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_used,
  output logic [WORDS-1:0]  valid_mask,
  output logic [LINE_W-1:0] line_flat
);
  logic [DATA_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  used_mask;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      valid_mask <= '0;
      used_mask  <= '0;
    end else begin
      if (wr_en)  valid_mask[wr_idx] <= 1'b1;
      if (use_en) used_mask[use_idx] <= 1'b1;
    end
  end

  assign rd_data  = mem[rd_idx];
  assign rd_valid = valid_mask[rd_idx];
  assign rd_used  = used_mask[rd_idx];

  for (genvar k = 0; k < WORDS; k++) begin : g_flat
    assign line_flat[k*DATA_W +: DATA_W] = mem[k];
  end

  // R9: a word can only be marked used once it has arrived
  a_r9_used_subset: assert property (@(posedge clk) disable iff (rst)
    (used_mask & ~valid_mask) == '0);
endmodule

// File: rtl/cwf_fill_buffer.sv
module cwf_fill_buffer
  import cwf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  localparam int OFF_W    = $clog2(WORDS),
  localparam int BYTE_W   = $clog2(DATA_W / 8),
  localparam int LINE_LSB = OFF_W + BYTE_W,
  localparam int TAG_W    = ADDR_W - LINE_LSB,
  localparam int LINE_W   = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_miss,
  input  logic              fetch_nc,
  output logic              fetch_ack,
  output logic [DATA_W-1:0] fetch_data,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_dv,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_last,
  output logic              arr_wr_req,
  input  logic              arr_wr_grant,
  output logic [LINE_W-1:0] arr_line,
  output logic [TAG_W-1:0]  arr_line_addr
);
  localparam logic [ADDR_W-1:0] BYTE_MASK = ADDR_W'((1 << BYTE_W) - 1);

  fill_st_e          st;
  logic [TAG_W-1:0]  line_q;
  logic              nc_q;
  logic [TAG_W-1:0]  f_line;
  logic [OFF_W-1:0]  f_word;
  logic [OFF_W-1:0]  seq_idx;
  logic [OFF_W:0]    beat_cnt;
  logic [DATA_W-1:0] rd_data;
  logic              rd_valid, rd_used;
  logic [WORDS-1:0]  valid_mask;
  logic              match, beat, beat_hit, buf_ok, need_new, start, blocked;

  assign f_line = fetch_addr[ADDR_W-1:LINE_LSB];
  assign f_word = fetch_addr[LINE_LSB-1:BYTE_W];

  assign match    = fetch_req && (st != ST_IDLE) && (f_line == line_q);
  assign beat     = (st == ST_FILL) && bus_dv;
  assign beat_hit = beat && (seq_idx == f_word);
  assign buf_ok   = rd_valid && !(nc_q && rd_used);

  assign fetch_ack  = match && (buf_ok || beat_hit);
  assign fetch_data = buf_ok ? rd_data : bus_data;

  // a new burst: miss to another line, or refetch of a spent inhibited word
  assign need_new = fetch_req &&
                    ((!match && fetch_miss) || (match && st == ST_HOLD && !fetch_ack));
  assign start    = need_new && (st == ST_IDLE || st == ST_HOLD);
  assign blocked  = fetch_req && !match && fetch_miss;

  // the array write steps aside for any fetch that is not itself waiting on us
  assign arr_wr_req    = (st == ST_WRITE) && (!fetch_req || blocked);
  assign arr_line_addr = line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      line_q   <= '0;
      nc_q     <= 1'b0;
      bus_req  <= 1'b0;
      bus_addr <= '0;
    end else begin
      bus_req <= start;
      unique case (st)
        ST_FILL:  if (beat && bus_last) st <= nc_q ? ST_HOLD : ST_WRITE;
        ST_WRITE: if (arr_wr_req && arr_wr_grant) st <= ST_IDLE;
        default:  ;
      endcase
      if (start) begin
        st       <= ST_FILL;
        line_q   <= f_line;
        nc_q     <= fetch_nc;
        bus_addr <= fetch_addr & ~BYTE_MASK;
      end
    end
  end

  cwf_beat_seq #(.WORDS(WORDS)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_word (f_word),
    .beat       (beat),
    .word_idx   (seq_idx),
    .beat_cnt   (beat_cnt)
  );

  cwf_line_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .clear      (start),
    .wr_en      (beat),
    .wr_idx     (seq_idx),
    .wr_data    (bus_data),
    .use_en     (fetch_ack && nc_q),
    .use_idx    (f_word),
    .rd_idx     (f_word),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .rd_used    (rd_used),
    .valid_mask (valid_mask),
    .line_flat  (arr_line)
  );

  a_r1_req_pulse: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> !bus_req);

  a_r7_one_burst: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FILL && $past(st) == ST_FILL) |-> !bus_req);

  a_r6_write_yields: assert property (@(posedge clk) disable iff (rst)
    (arr_wr_req && fetch_req) |-> !fetch_ack);

  a_r8_nc_no_write: assert property (@(posedge clk) disable iff (rst)
    arr_wr_req |-> !nc_q);

  a_r4_fill_count: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FILL) |-> ($countones(valid_mask) == 32'(beat_cnt)));
endmodule

// File: tb/test_cwf_fill_buffer.sv
module test_cwf_fill_buffer;
  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic         rst = 1'b1;
  logic         fetch_req = 1'b0, fetch_miss = 1'b0, fetch_nc = 1'b0;
  logic [31:0]  fetch_addr = '0;
  logic         fetch_ack;
  logic [31:0]  fetch_data;
  logic         bus_req;
  logic [31:0]  bus_addr;
  logic         bus_dv = 1'b0, bus_last = 1'b0;
  logic [31:0]  bus_data = '0;
  logic         arr_wr_req;
  logic         arr_wr_grant = 1'b0;
  logic [127:0] arr_line;
  logic [27:0]  arr_line_addr;

  cwf_fill_buffer i_cwf_fill_buffer (
    .clk(clk), .rst(rst),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_miss(fetch_miss), .fetch_nc(fetch_nc),
    .fetch_ack(fetch_ack), .fetch_data(fetch_data),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_dv(bus_dv), .bus_data(bus_data), .bus_last(bus_last),
    .arr_wr_req(arr_wr_req), .arr_wr_grant(arr_wr_grant), .arr_line(arr_line), .arr_line_addr(arr_line_addr)
  );

  int n_chk = 0, n_err = 0, bus_reqs = 0, bus_lat = 2, bus_gap = 0, w = 0;
  logic [31:0] last_bus_addr = '0, mon_e;
  string mon_t;
  bit nc_phase = 0, wr_seen_nc = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  function automatic logic [31:0] wval(logic [31:0] a);
    return {a[31:4], 2'b01, a[3:2]};
  endfunction

  function automatic logic [127:0] lval(logic [31:0] a);
    return {wval({a[31:4], 4'hC}), wval({a[31:4], 4'h8}), wval({a[31:4], 4'h4}), wval({a[31:4], 4'h0})};
  endfunction

  task automatic chk(bit ok, string r, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // monitor: scoreboard pop on every acknowledge
  always @(negedge clk) begin
    if (!rst) begin
      if (fetch_ack) begin
        if (exp_q.size() == 0) chk(0, "R9 unexpected acknowledge", fetch_data, 0);
        else begin
          mon_e = exp_q.pop_front();
          mon_t = tag_q.pop_front();
          chk(fetch_data == mon_e, mon_t, fetch_data, mon_e);
        end
      end
      if (bus_req) begin bus_reqs++; last_bus_addr = bus_addr; end
      if (arr_wr_req && nc_phase) wr_seen_nc = 1;
    end
  end

  // bus model: wrap-around burst starting at the requested word
  initial begin
    logic [31:0] ba;
    forever begin
      @(negedge clk);
      if (bus_req) begin
        ba = bus_addr;
        @(posedge clk); #1;
        repeat (bus_lat) begin @(posedge clk); #1; end
        for (int i = 0; i < 4; i++) begin
          bus_dv = 1'b1;
          bus_data = wval({ba[31:4], 2'(ba[3:2] + 2'(i)), 2'b00});
          bus_last = (i == 3);
          @(posedge clk); #1;
          if (bus_gap > 0) begin
            bus_dv = 1'b0; bus_last = 1'b0;
            repeat (bus_gap) begin @(posedge clk); #1; end
          end
        end
        bus_dv = 1'b0; bus_last = 1'b0;
      end
    end
  end

  task automatic do_fetch(input logic [31:0] a, input bit miss, input bit nc, input string tag,
                          output int waited);
    exp_q.push_back(wval(a));
    tag_q.push_back(tag);
    @(posedge clk); #1;
    fetch_req = 1'b1; fetch_addr = a; fetch_miss = miss; fetch_nc = nc;
    waited = 0;
    forever begin
      @(negedge clk);
      if (fetch_ack) break;
      waited++;
    end
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    fetch_req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_fetch(input logic [31:0] a, input bit miss, input int n, input string r,
                            input bit exp_wr);
    @(posedge clk); #1;
    fetch_req = 1'b1; fetch_addr = a; fetch_miss = miss; fetch_nc = 1'b0;
    repeat (n) begin
      @(negedge clk);
      chk(!fetch_ack, {r, " no acknowledge"}, fetch_ack, 0);
      chk(arr_wr_req == exp_wr, {r, " write request"}, arr_wr_req, exp_wr);
    end
  endtask

  task automatic grant();
    @(posedge clk); #1 arr_wr_grant = 1'b1;
    @(posedge clk); #1 arr_wr_grant = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!bus_req && !fetch_ack && !arr_wr_req, "R11 reset state",
        {bus_req, fetch_ack, arr_wr_req}, 0);

    // S1: cacheable miss on word 2, gapped beats
    bus_gap = 2;
    do_fetch(32'h0000_1238, 1, 0, "R2 critical word data", w);
    chk(bus_dv && fetch_data == bus_data, "R3 critical word same cycle", bus_dv, 1);
    chk(bus_reqs == 1 && last_bus_addr == 32'h0000_1238, "R1 burst request", last_bus_addr, 32'h1238);
    do_fetch(32'h0000_1238, 1, 0, "R4 buffer data", w);
    chk(w == 0, "R4 buffered word immediate", w, 0);
    do_fetch(32'h0000_123C, 1, 0, "R2 word3 data", w);
    chk(w > 0, "R4 stall until word lands", w, 1);
    do_fetch(32'h0000_1230, 1, 0, "R2 wrapped word0 data", w);
    do_fetch(32'h0000_1234, 1, 0, "R2 wrapped word1 data", w);
    idle(1);
    chk(arr_wr_req, "R5 write request", arr_wr_req, 1);
    chk(arr_line == lval(32'h1230), "R5 line contents", arr_line, lval(32'h1230));
    chk(arr_line_addr == 28'h123, "R5 line address", arr_line_addr, 28'h123);

    // array hit to another line: ignored, write yields
    hold_fetch(32'h0000_9000, 0, 3, "R6 R10", 0);
    chk(bus_reqs == 1, "R10 no burst for array hit", bus_reqs, 1);
    // blocked miss to another line: write proceeds, no new burst
    hold_fetch(32'h0000_2004, 1, 3, "R7", 1);
    chk(bus_reqs == 1, "R7 no burst while write pending", bus_reqs, 1);
    grant();

    // S2: the blocked miss now proceeds, back-to-back beats
    bus_gap = 0;
    do_fetch(32'h0000_2004, 1, 0, "R7 critical data after grant", w);
    chk(bus_reqs == 2 && last_bus_addr == 32'h0000_2004, "R7 burst after grant", last_bus_addr, 32'h2004);
    do_fetch(32'h0000_2008, 1, 0, "R4 stream word2 data", w);
    chk(w == 0, "R4 word from bus same cycle", w, 0);
    do_fetch(32'h0000_200C, 1, 0, "R4 stream word3 data", w);
    do_fetch(32'h0000_2000, 1, 0, "R2 wrapped word0 data", w);
    idle(1);
    chk(arr_wr_req && arr_line_addr == 28'h200, "R5 second line address", arr_line_addr, 28'h200);
    chk(arr_line == lval(32'h2000), "R5 second line contents", arr_line, lval(32'h2000));
    grant();
    @(negedge clk);
    chk(!arr_wr_req, "R5 released after grant", arr_wr_req, 0);

    // S3: caching-inhibited line
    nc_phase = 1; bus_gap = 1;
    do_fetch(32'h0000_3008, 1, 1, "R8 inhibited critical data", w);
    do_fetch(32'h0000_300C, 1, 1, "R8 inhibited word3 data", w);
    idle(10);
    do_fetch(32'h0000_3000, 1, 1, "R9 unused word data", w);
    chk(w == 0 && bus_reqs == 3, "R9 unused word from buffer", bus_reqs, 3);
    do_fetch(32'h0000_3008, 1, 1, "R9 refetch data", w);
    chk(w > 0 && bus_reqs == 4 && last_bus_addr == 32'h0000_3008, "R9 used word refetched",
        last_bus_addr, 32'h3008);
    idle(10);
    chk(!wr_seen_nc, "R8 no array write for inhibited line", wr_seen_nc, 0);
    nc_phase = 0;

    // S4: miss to another line discards the inhibited buffer at once
    do_fetch(32'h0000_4004, 1, 0, "R9 discard critical data", w);
    chk(bus_reqs == 5 && last_bus_addr == 32'h0000_4004, "R9 discard starts burst", last_bus_addr, 32'h4004);
    idle(10);
    chk(arr_wr_req && arr_line == lval(32'h4000), "R5 third line contents", arr_line, lval(32'h4000));
    grant();
    @(negedge clk);
    chk(exp_q.size() == 0, "R4 all expected acknowledges seen", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule